// File: doc/BRIEF.md
# UART Interrupt Status Combiner

This block holds the interrupt state of a serial port: an 11-bit sticky raw status vector and an 11-bit enable mask. Event sources elsewhere in the port raise raw bits with single-cycle pulses. Software reads back the raw vector, the mask and the masked vector. It writes the mask and acknowledges events by writing ones to a clear strobe.

Six interrupt lines leave the block. Each is the OR of the masked status inside one fixed group of bits. The groups are receive, transmit, receive timeout, modem status and line error, plus one combined line that covers all eleven bits. Each line is registered, so it is free of glitches and follows the raw/mask state one clock later.

The register interface is reduced to plain word-wide write strobes and always-valid readback buses. No data stream passes through the block, so no valid/ready handshake and no back-pressure apply.

Top module: `uart_irq_combiner`

## Requirements
- R1: While `rst_n` is low, and at the first clock after it rises, the raw status, the mask and all six interrupt lines are 0.
- R2: A 1 on bit k of `evt_set` at a rising clock edge makes `raw_rdata[k]` 1 after that edge. The bit stays 1 until a clear write removes it. Bit positions are: overrun 10, break 9, parity 8, framing 7, receive timeout 6, transmit 5, receive 4, DSR 3, DCD 2, CTS 1, RI 0.
- R3: A cycle with `clr_we` high clears exactly those raw bits that are 1 in `clr_wdata`. All other raw bits keep their value.
- R4: When a set pulse and a clear write hit the same bit in the same cycle, the bit ends up 1.
- R5: `masked_rdata` always equals `raw_rdata & mask_rdata`, with no added delay.
- R6: A cycle with `mask_we` high loads `mask_wdata` into the mask, which is visible on `mask_rdata` after that edge. Otherwise the mask holds its value.
- R7: `irq_rx`, `irq_tx` and `irq_rto` are the registered values of masked bits 4, 5 and 6. `irq_modem` is the registered OR of masked bits 3..0. `irq_err` is the registered OR of masked bits 10..7. Each line shows, after edge N+1, the state that held after edge N.
- R8: `irq_any` is the registered OR of all eleven masked bits, with the same one-cycle lag as R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set | input | 11 | Per-bit single-cycle set pulses from event sources |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 11 | New mask value |
| clr_we | input | 1 | Clear write strobe |
| clr_wdata | input | 11 | Ones select the raw bits to clear |
| raw_rdata | output | 11 | Raw status readback |
| mask_rdata | output | 11 | Mask readback |
| masked_rdata | output | 11 | Raw AND mask readback |
| irq_any | output | 1 | Combined interrupt line |
| irq_rx | output | 1 | Receive interrupt line |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rto | output | 1 | Receive timeout interrupt line |
| irq_modem | output | 1 | Modem status group line |
| irq_err | output | 1 | Line error group line |

## Verification
The two functions that can fall in the same cycle are an event setting a raw bit and software clearing that same bit. The bench provokes this by driving `evt_set` and `clr_we` in the same cycle. It does so both on bits that are already pending and on bits that are clear, with the clear word covering more bits than the set word. The result is judged at the raw readback one cycle later: every set bit must survive, and every other bit in the clear word must be gone. A mask write in the same cycle as a set pulse is also exercised. The interrupt lines are judged one cycle after that.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int STAT_W    = 11;
  localparam int NUM_LINES = 6;

  localparam int BIT_RI  = 0;
  localparam int BIT_CTS = 1;
  localparam int BIT_DCD = 2;
  localparam int BIT_DSR = 3;
  localparam int BIT_RX  = 4;
  localparam int BIT_TX  = 5;
  localparam int BIT_RTO = 6;
  localparam int BIT_FRM = 7;
  localparam int BIT_PAR = 8;
  localparam int BIT_BRK = 9;
  localparam int BIT_OVR = 10;

  typedef logic [STAT_W-1:0] stat_t;

  typedef enum int {
    LINE_ANY   = 0,
    LINE_RX    = 1,
    LINE_TX    = 2,
    LINE_RTO   = 3,
    LINE_MODEM = 4,
    LINE_ERR   = 5
  } line_e;

  localparam stat_t GRP_MODEM = stat_t'((1 << BIT_RI) | (1 << BIT_CTS) |
                                        (1 << BIT_DCD) | (1 << BIT_DSR));
  localparam stat_t GRP_ERR   = stat_t'((1 << BIT_FRM) | (1 << BIT_PAR) |
                                        (1 << BIT_BRK) | (1 << BIT_OVR));

  function automatic stat_t line_group(input int idx);
    stat_t g;
    case (idx)
      LINE_ANY:   g = GRP_ERR | GRP_MODEM | stat_t'((1 << BIT_RTO) |
                                                    (1 << BIT_TX) | (1 << BIT_RX));
      LINE_RX:    g = stat_t'(1 << BIT_RX);
      LINE_TX:    g = stat_t'(1 << BIT_TX);
      LINE_RTO:   g = stat_t'(1 << BIT_RTO);
      LINE_MODEM: g = GRP_MODEM;
      default:    g = GRP_ERR;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/irq_raw_store.sv
module irq_raw_store
  import uart_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  stat_t set_i,
  input  logic  clr_en_i,
  input  stat_t clr_bits_i,
  output stat_t raw_o
);
  stat_t raw_q;
  stat_t clr_eff;
  stat_t raw_d;

  always_comb begin
    clr_eff = clr_en_i ? clr_bits_i : '0;
    // set is applied after clear so a colliding event survives
    raw_d   = (raw_q & ~clr_eff) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/irq_mask_store.sv
module irq_mask_store
  import uart_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we_i,
  input  stat_t wdata_i,
  output stat_t mask_o
);
  stat_t mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (we_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_line_driver.sv
module irq_line_driver
  import uart_irq_pkg::*;
#(
  parameter stat_t GROUP = '1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  stat_t pending_i,
  output logic  line_o
);
  logic hit;
  logic line_q;

  assign hit = |(pending_i & GROUP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= hit;
  end

  assign line_o = line_q;
endmodule

// File: rtl/uart_irq_combiner.sv
module uart_irq_combiner
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] evt_set,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] mask_wdata,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_wdata,
  output logic [STAT_W-1:0] raw_rdata,
  output logic [STAT_W-1:0] mask_rdata,
  output logic [STAT_W-1:0] masked_rdata,
  output logic              irq_any,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_rto,
  output logic              irq_modem,
  output logic              irq_err
);
  stat_t raw_s;
  stat_t mask_s;
  stat_t pend_s;
  logic [NUM_LINES-1:0] lines;

  irq_raw_store u_raw (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (evt_set),
    .clr_en_i   (clr_we),
    .clr_bits_i (clr_wdata),
    .raw_o      (raw_s)
  );

  irq_mask_store u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (mask_we),
    .wdata_i (mask_wdata),
    .mask_o  (mask_s)
  );

  assign pend_s = raw_s & mask_s;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irq_line_driver #(
      .GROUP (line_group(g))
    ) u_drv (
      .clk       (clk),
      .rst_n     (rst_n),
      .pending_i (pend_s),
      .line_o    (lines[g])
    );
  end

  assign raw_rdata    = raw_s;
  assign mask_rdata   = mask_s;
  assign masked_rdata = pend_s;
  assign irq_any      = lines[LINE_ANY];
  assign irq_rx       = lines[LINE_RX];
  assign irq_tx       = lines[LINE_TX];
  assign irq_rto      = lines[LINE_RTO];
  assign irq_modem    = lines[LINE_MODEM];
  assign irq_err      = lines[LINE_ERR];
endmodule

// File: rtl/uart_irq_combiner_chk.sv
module uart_irq_combiner_chk
  import uart_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [STAT_W-1:0] evt_set,
  input logic              mask_we,
  input logic [STAT_W-1:0] mask_wdata,
  input logic              clr_we,
  input logic [STAT_W-1:0] clr_wdata,
  input logic [STAT_W-1:0] raw_rdata,
  input logic [STAT_W-1:0] mask_rdata,
  input logic [STAT_W-1:0] masked_rdata,
  input logic              irq_any,
  input logic              irq_rx,
  input logic              irq_tx,
  input logic              irq_rto,
  input logic              irq_modem,
  input logic              irq_err
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_state_R1: assert (raw_rdata == '0 && mask_rdata == '0 &&
                                     !irq_any && !irq_err && !irq_modem);
    end
  end

  assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((raw_rdata & $past(raw_rdata)) == $past(raw_rdata)));

  assert_clear_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((raw_rdata & $past(clr_wdata & ~evt_set)) == '0));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((raw_rdata & $past(evt_set)) == $past(evt_set)));

  assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_rdata == $past(mask_wdata)));

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_rdata));

  assert_err_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_err == (|($past(masked_rdata) & GRP_ERR))));

  assert_modem_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_modem == (|($past(masked_rdata) & GRP_MODEM))));

  assert_single_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({irq_rto, irq_tx, irq_rx} == $past(masked_rdata[BIT_RTO:BIT_RX])));

  assert_any_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_any == (|$past(masked_rdata))));
endmodule

bind uart_irq_combiner uart_irq_combiner_chk chk_i (.*);

// File: tb/uart_irq_combiner_tb_top.sv
module uart_irq_combiner_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] evt_set = '0;
  logic        mask_we = 1'b0;
  logic [10:0] mask_wdata = '0;
  logic        clr_we = 1'b0;
  logic [10:0] clr_wdata = '0;
  logic [10:0] raw_rdata, mask_rdata, masked_rdata;
  logic        irq_any, irq_rx, irq_tx, irq_rto, irq_modem, irq_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [10:0] m_raw;
  logic [10:0] m_mask;

  always #4 clk = ~clk;

  uart_irq_combiner dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_lines(input logic [10:0] p);
    // {err, modem, rto, tx, rx, any}
    return {|p[10:7], |p[3:0], p[6], p[5], p[4], |p};
  endfunction

  function automatic logic [5:0] got_lines();
    return {irq_err, irq_modem, irq_rto, irq_tx, irq_rx, irq_any};
  endfunction

  // one cycle: drive at negedge, wait to next negedge
  task automatic step(input logic [10:0] s, input logic cwe, input logic [10:0] cd,
                      input logic mwe, input logic [10:0] md);
    evt_set = s; clr_we = cwe; clr_wdata = cd; mask_we = mwe; mask_wdata = md;
    @(negedge clk);
    evt_set = '0; clr_we = 1'b0; clr_wdata = '0; mask_we = 1'b0; mask_wdata = '0;
    if (cwe) m_raw = m_raw & ~cd;
    m_raw = m_raw | s;
    if (mwe) m_mask = md;
  endtask

  task automatic check_state(input string tag);
    check({tag, " raw R2/R3"}, 32'(raw_rdata), 32'(m_raw));
    check({tag, " mask R6"}, 32'(mask_rdata), 32'(m_mask));
    check({tag, " masked R5"}, 32'(masked_rdata), 32'(m_raw & m_mask));
  endtask

  task automatic check_lines_next(input string tag);
    logic [10:0] p;
    p = m_raw & m_mask;
    @(negedge clk);
    check({tag, " lines R7/R8"}, 32'(got_lines()), 32'(exp_lines(p)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_raw = '0; m_mask = '0;
    repeat (3) @(negedge clk);
    check("R1 raw in reset", 32'(raw_rdata), 0);
    check("R1 mask in reset", 32'(mask_rdata), 0);
    check("R1 lines in reset", 32'(got_lines()), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 lines after reset", 32'(got_lines()), 0);
    check_state("R1 after reset");

    // R2: each bit alone, mask all ones, then clear it (R3)
    step('0, 1'b0, '0, 1'b1, 11'h7FF);
    for (int k = 0; k < 11; k++) begin
      step(11'(1 << k), 1'b0, '0, 1'b0, '0);
      check_state("R2 single bit");
      check_lines_next("R2 single bit");
      check_state("R2 bit sticky");
      step('0, 1'b1, 11'(1 << k), 1'b0, '0);
      check_state("R3 single clear");
      check_lines_next("R3 single clear");
    end

    // R5-R8: raw all ones, sweep every mask value
    step(11'h7FF, 1'b0, '0, 1'b0, '0);
    for (int m = 0; m < 2048; m++) begin
      step('0, 1'b0, '0, 1'b1, 11'(m));
      check_state("R6 mask sweep");
      check_lines_next("R8 mask sweep");
    end

    // R3: clear patterns over full raw, mask all ones
    step('0, 1'b0, '0, 1'b1, 11'h7FF);
    for (int c = 0; c < 2048; c += 37) begin
      step(11'h7FF, 1'b0, '0, 1'b0, '0);
      step('0, 1'b1, 11'(c), 1'b0, '0);
      check_state("R3 clear pattern");
      check_lines_next("R7 clear pattern");
    end

    // R4: set and clear collide
    step(11'h7FF, 1'b0, '0, 1'b0, '0);
    step(11'h008, 1'b1, 11'h7FF, 1'b0, '0);
    check("R4 collide on pending bit", 32'(raw_rdata), 32'h008);
    step('0, 1'b1, 11'h7FF, 1'b0, '0);
    step(11'h480, 1'b1, 11'h4C1, 1'b0, '0);
    check("R4 collide on idle bit", 32'(raw_rdata), 32'h480);
    check_lines_next("R4 collide");
    for (int s = 1; s < 2048; s += 53) begin
      step(11'h2AA, 1'b0, '0, 1'b0, '0);
      step(11'(s), 1'b1, 11'h7FF, 1'b1, 11'(~s));
      check_state("R4 collide sweep");
      check_lines_next("R4 collide sweep");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule